// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds two kinds of pending interrupt for each processor in a system of up to four. The first kind is the inter-processor interrupt (IPI). Software raises it for one or more target processors and later acknowledges it. The second kind is the timer interrupt. An external periodic tick raises it, and software acknowledges it. Each processor gets two level outputs, one per kind, and each output follows its pending bit directly.

Software reaches the block through a simple register port with a 2-bit register select. The control register packs three per-processor 4-bit masks into one 64-bit write: raise IPIs, acknowledge IPIs and acknowledge timer interrupts. Three dedicated registers give a second way to reach the same state. A one-cycle error pulse reports a write that names no processor. A one-cycle warning pulse reports a redundant IPI raise or a redundant IPI acknowledge. A read of the control register returns the pending state together with the number of the processor that issued the read.

Top module: `ipi_timer_intc`

## Requirements
- R1: After reset every pending bit is clear and ipi_irq, tmr_irq, rdata, rd_valid, err_pulse and warn_pulse are all zero.
- R2: A write with reg_sel = 0 (control register) sets the IPI pending bit of CPU n when wdata[12+n] is 1. The new value shows on ipi_irq after the clock edge that samples the write.
- R3: A control-register write clears the IPI pending bit of CPU n when wdata[8+n] is 1, and clears the timer pending bit of CPU n when wdata[4+n] is 1. One write can raise and acknowledge through all three fields at once.
- R4: A control-register write where wdata[15:4] and wdata[28] are all zero is an error: err_pulse is 1 in the following cycle and no state changes. A write with only wdata[28] set is accepted, with no error, no warning and no state change.
- R5: Raising an IPI that is already pending, or acknowledging one that is not pending, makes warn_pulse 1 in the following cycle and leaves that bit as it was. Both cases are judged against the state before the write.
- R6: When tick is 1 at a clock edge, the timer pending bit is set for every processor below CPU_COUNT.
- R7: Dedicated registers use wdata[3:0] as a per-CPU mask. A write with reg_sel = 1 raises IPIs, reg_sel = 2 acknowledges IPIs and reg_sel = 3 acknowledges timer interrupts. When wdata[3:0] is zero the write is an error and changes nothing.
- R8: A read (rd_en) gives rd_valid = 1 and the data on rdata one cycle later. Reading reg_sel = 0 returns the IPI pending bits in [11:8], the timer pending bits in [7:4] and req_cpu in [1:0], with every other bit zero. Reading reg_sel = 2 or 3 returns the IPI or timer pending bits in [3:0]. Reading reg_sel = 1 returns zero.
- R9: A processor numbered at or above CPU_COUNT is never set, never warned about, and its outputs stay 0.
- R10: If a set and a clear reach the same pending bit in one cycle, the set wins. This covers a tick together with a timer acknowledge, and an IPI raise together with an IPI acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 IPI raise, 2 IPI pending, 3 timer pending |
| wdata | input | DATA_W | Write data |
| req_cpu | input | 2 | Number of the processor issuing the access |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| rdata | output | DATA_W | Read data, valid while rd_valid is 1 |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| ipi_irq | output | 4 | Per-CPU IPI level interrupt |
| tmr_irq | output | 4 | Per-CPU timer level interrupt |
| err_pulse | output | 1 | Write named no processor |
| warn_pulse | output | 1 | Redundant IPI raise or acknowledge |

## Verification
The hardest case to reach is a collision on one pending bit, where a set and a clear meet in the same cycle. Only two stimuli produce it. One is a tick in the same cycle as a timer-acknowledge write. The other is a control-register write whose raise and acknowledge fields both name the same processor. The bench drives both, sets up the pending state first so the outcome is visible, and then issues a plain acknowledge to show the bit can still fall. The bench is built with CPU_COUNT = 3, so the writes and ticks aimed at the fourth slot also check that the masks leave that slot untouched.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
   localparam int NSLOT     = 4;
   localparam int CPU_ID_W  = 2;
   localparam int IPI_SET_LO = 12;
   localparam int IPI_CLR_LO = 8;
   localparam int TMR_CLR_LO = 4;
   localparam int NXM_ACK_BIT = 28;
   localparam int RD_FIELD_TOP = 12;

   typedef enum logic [1:0] {
      SEL_CTRL     = 2'd0,
      SEL_IPI_RAISE = 2'd1,
      SEL_IPI_PEND = 2'd2,
      SEL_TMR_PEND = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [NSLOT-1:0] ipi_set;
      logic [NSLOT-1:0] ipi_clr;
      logic [NSLOT-1:0] tmr_clr;
      logic             empty;
   } wr_cmd_t;
endpackage

// File: rtl/intc_wr_decode.sv
module intc_wr_decode
   import ipi_tmr_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int CPU_COUNT = 4
) (
   input  logic              wr_en,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] wdata,
   output wr_cmd_t           cmd
);
   localparam logic [NSLOT-1:0] LIVE = NSLOT'((1 << CPU_COUNT) - 1);

   logic [NSLOT-1:0] f_set, f_clr, f_tclr, low_mask;
   logic             nxm_ack;
   logic             unused_bits;

   assign f_set    = wdata[IPI_SET_LO +: NSLOT];
   assign f_clr    = wdata[IPI_CLR_LO +: NSLOT];
   assign f_tclr   = wdata[TMR_CLR_LO +: NSLOT];
   assign low_mask = wdata[NSLOT-1:0];
   assign nxm_ack  = wdata[NXM_ACK_BIT];
   assign unused_bits = ^{wdata[DATA_W-1:NXM_ACK_BIT+1], wdata[NXM_ACK_BIT-1:IPI_SET_LO+NSLOT]};

   always_comb begin
      cmd = '0;
      if (wr_en) begin
         unique case (reg_sel_e'(reg_sel))
            SEL_CTRL: begin
               cmd.ipi_set = f_set & LIVE;
               cmd.ipi_clr = f_clr & LIVE;
               cmd.tmr_clr = f_tclr & LIVE;
               cmd.empty   = ~|{f_set, f_clr, f_tclr, nxm_ack};
            end
            SEL_IPI_RAISE: begin
               cmd.ipi_set = low_mask & LIVE;
               cmd.empty   = ~|low_mask;
            end
            SEL_IPI_PEND: begin
               cmd.ipi_clr = low_mask & LIVE;
               cmd.empty   = ~|low_mask;
            end
            SEL_TMR_PEND: begin
               cmd.tmr_clr = low_mask & LIVE;
               cmd.empty   = ~|low_mask;
            end
            default: cmd = '0;
         endcase
      end
   end
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank
   import ipi_tmr_pkg::*;
#(
   parameter int CPU_COUNT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] set_mask,
   input  logic [NSLOT-1:0] clr_mask,
   output logic [NSLOT-1:0] pend
);
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (g < CPU_COUNT) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)           pend[g] <= 1'b0;
            else if (set_mask[g]) pend[g] <= 1'b1;
            else if (clr_mask[g]) pend[g] <= 1'b0;
         end
      end else begin : g_absent
         logic unused_in;
         assign unused_in = set_mask[g] | clr_mask[g];
         assign pend[g]   = 1'b0;
      end
   end
endmodule

// File: rtl/intc_readback.sv
module intc_readback
   import ipi_tmr_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [1:0]          reg_sel,
   input  logic [CPU_ID_W-1:0] req_cpu,
   input  logic [NSLOT-1:0]    ipi_pend,
   input  logic [NSLOT-1:0]    tmr_pend,
   output logic [DATA_W-1:0]   rdata,
   output logic                rd_valid
);
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      unique case (reg_sel_e'(reg_sel))
         SEL_CTRL: begin
            rd_mux[IPI_CLR_LO +: NSLOT] = ipi_pend;
            rd_mux[TMR_CLR_LO +: NSLOT] = tmr_pend;
            rd_mux[CPU_ID_W-1:0]        = req_cpu;
         end
         SEL_IPI_PEND:  rd_mux[NSLOT-1:0] = ipi_pend;
         SEL_TMR_PEND:  rd_mux[NSLOT-1:0] = tmr_pend;
         default:       rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rdata    <= rd_en ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
   import ipi_tmr_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int CPU_COUNT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        req_cpu,
   input  logic              tick,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic [3:0]        ipi_irq,
   output logic [3:0]        tmr_irq,
   output logic              err_pulse,
   output logic              warn_pulse
);
   if (CPU_COUNT < 1 || CPU_COUNT > NSLOT) begin : g_bad_count
      $error("CPU_COUNT must lie in 1..%0d", NSLOT);
   end
   if (DATA_W < 32) begin : g_bad_width
      $error("DATA_W must be at least 32");
   end

   wr_cmd_t          cmd;
   logic [NSLOT-1:0] ipi_pend, tmr_pend, tick_mask;
   logic             warn_d;

   intc_wr_decode #(.DATA_W(DATA_W), .CPU_COUNT(CPU_COUNT)) u_dec (
      .wr_en  (wr_en),
      .reg_sel(reg_sel),
      .wdata  (wdata),
      .cmd    (cmd)
   );

   intc_pend_bank #(.CPU_COUNT(CPU_COUNT)) u_ipi (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mask(cmd.ipi_set),
      .clr_mask(cmd.ipi_clr),
      .pend    (ipi_pend)
   );

   assign tick_mask = {NSLOT{tick}};

   intc_pend_bank #(.CPU_COUNT(CPU_COUNT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mask(tick_mask),
      .clr_mask(cmd.tmr_clr),
      .pend    (tmr_pend)
   );

   intc_readback #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .reg_sel (reg_sel),
      .req_cpu (req_cpu),
      .ipi_pend(ipi_pend),
      .tmr_pend(tmr_pend),
      .rdata   (rdata),
      .rd_valid(rd_valid)
   );

   // redundant raise or acknowledge, judged against the pre-write state
   assign warn_d = |((cmd.ipi_set & ipi_pend) | (cmd.ipi_clr & ~ipi_pend));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_pulse  <= 1'b0;
         warn_pulse <= 1'b0;
      end else begin
         err_pulse  <= cmd.empty;
         warn_pulse <= warn_d;
      end
   end

   assign ipi_irq = ipi_pend;
   assign tmr_irq = tmr_pend;
endmodule

// File: rtl/ipi_timer_intc_chk.sv
module ipi_timer_intc_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              tick,
   input logic [DATA_W-1:0] rdata,
   input logic              rd_valid,
   input logic [3:0]        ipi_irq,
   input logic [3:0]        tmr_irq,
   input logic              err_pulse,
   input logic              warn_pulse
);
   AST_IPI_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((ipi_irq & ~$past(ipi_irq)) != 4'b0) |-> $past(wr_en)); // R2

   AST_IPI_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((~ipi_irq & $past(ipi_irq)) != 4'b0) |-> $past(wr_en)); // R3

   AST_TMR_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ((~tmr_irq & $past(tmr_irq)) != 4'b0) |-> $past(wr_en)); // R3

   AST_TMR_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ((tmr_irq & ~$past(tmr_irq)) != 4'b0) |-> $past(tick)); // R6

   AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(wr_en)); // R4

   AST_ERR_KEEPS_IPI: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (ipi_irq == $past(ipi_irq))); // R4

   AST_WARN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      warn_pulse |-> $past(wr_en)); // R5

   AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rdata[DATA_W-1:12] == '0)); // R8
endmodule

bind ipi_timer_intc ipi_timer_intc_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .tick      (tick),
   .rdata     (rdata),
   .rd_valid  (rd_valid),
   .ipi_irq   (ipi_irq),
   .tmr_irq   (tmr_irq),
   .err_pulse (err_pulse),
   .warn_pulse(warn_pulse)
);

// File: tb/sim_ipi_timer_intc.sv
`timescale 1ns/1ps
module sim_ipi_timer_intc;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
   logic [1:0]    reg_sel = 2'd0, req_cpu = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rd_valid, err_pulse, warn_pulse;
   logic [3:0]    ipi_irq, tmr_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ipi_timer_intc #(.DATA_W(DW), .CPU_COUNT(3)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
      .wdata(wdata), .req_cpu(req_cpu), .tick(tick), .rdata(rdata), .rd_valid(rd_valid),
      .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err_pulse(err_pulse), .warn_pulse(warn_pulse)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [63:0] d, input logic tk);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wdata = d; tick = tk;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0; wdata = '0;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] sel, input logic [1:0] cpu);
      @(negedge clk);
      rd_en = 1'b1; reg_sel = sel; req_cpu = cpu;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ipi_irq", ipi_irq, 0);
      chk("R1 tmr_irq", tmr_irq, 0);
      chk("R1 rdata", rdata, 0);
      chk("R1 rd_valid", rd_valid, 0);
      chk("R1 err_pulse", err_pulse, 0);
      chk("R1 warn_pulse", warn_pulse, 0);
   endtask

   task automatic t_raise();
      do_write(2'd0, 64'h3000, 1'b0);
      chk("R2 ipi after raise cpu0,1", ipi_irq, 4'b0011);
      chk("R2 no warn", warn_pulse, 0);
      chk("R2 no err", err_pulse, 0);
   endtask

   task automatic t_redundant();
      do_write(2'd0, 64'h1000, 1'b0);
      chk("R5 warn on duplicate raise", warn_pulse, 1);
      chk("R5 ipi unchanged", ipi_irq, 4'b0011);
      do_write(2'd0, 64'h0400, 1'b0);
      chk("R5 warn on clear of idle", warn_pulse, 1);
      chk("R5 ipi unchanged after clear", ipi_irq, 4'b0011);
   endtask

   task automatic t_tick_and_combo();
      do_tick();
      chk("R6 tick sets live cpus", tmr_irq, 4'b0111);
      do_write(2'd0, 64'h4120, 1'b0);
      chk("R3 combined ipi", ipi_irq, 4'b0110);
      chk("R3 combined tmr", tmr_irq, 4'b0101);
      chk("R3 no warn", warn_pulse, 0);
   endtask

   task automatic t_empty();
      do_write(2'd0, 64'h0, 1'b0);
      chk("R4 empty write err", err_pulse, 1);
      chk("R4 empty keeps ipi", ipi_irq, 4'b0110);
      do_write(2'd0, 64'h1000_0000, 1'b0);
      chk("R4 nxm ack no err", err_pulse, 0);
      chk("R4 nxm ack no warn", warn_pulse, 0);
      chk("R4 nxm ack keeps tmr", tmr_irq, 4'b0101);
      do_write(2'd0, 64'h000F, 1'b0);
      chk("R4 low bits only err", err_pulse, 1);
   endtask

   task automatic t_readback();
      do_read(2'd0, 2'd2);
      chk("R8 rd_valid", rd_valid, 1);
      chk("R8 ctrl read", rdata, 64'h652);
      do_read(2'd2, 2'd0);
      chk("R8 ipi pend read", rdata, 64'h6);
      do_read(2'd3, 2'd1);
      chk("R8 tmr pend read", rdata, 64'h5);
      do_read(2'd1, 2'd3);
      chk("R8 raise reg reads zero", rdata, 64'h0);
      @(negedge clk);
      chk("R8 rd_valid drops", rd_valid, 0);
   endtask

   task automatic t_dedicated();
      do_write(2'd1, 64'h1, 1'b0);
      chk("R7 raise reg", ipi_irq, 4'b0111);
      do_write(2'd2, 64'h6, 1'b0);
      chk("R7 ipi ack reg", ipi_irq, 4'b0001);
      do_write(2'd3, 64'h5, 1'b0);
      chk("R7 tmr ack reg", tmr_irq, 4'b0000);
      do_write(2'd2, 64'h0, 1'b0);
      chk("R7 empty ack err", err_pulse, 1);
      do_write(2'd1, 64'hF0, 1'b0);
      chk("R7 high-only mask err", err_pulse, 1);
      chk("R7 high-only keeps ipi", ipi_irq, 4'b0001);
   endtask

   task automatic t_cpu_limit();
      do_write(2'd1, 64'h8, 1'b0);
      chk("R9 cpu3 raise no effect", ipi_irq, 4'b0001);
      chk("R9 cpu3 raise no warn", warn_pulse, 0);
      chk("R9 cpu3 raise no err", err_pulse, 0);
      do_tick();
      chk("R9 tick skips cpu3", tmr_irq, 4'b0111);
      do_write(2'd0, 64'h8800, 1'b0);
      chk("R9 ctrl cpu3 no effect", ipi_irq, 4'b0001);
      chk("R9 ctrl cpu3 no warn", warn_pulse, 0);
   endtask

   task automatic t_set_wins();
      do_write(2'd3, 64'h1, 1'b1);
      chk("R10 tick beats tmr ack", tmr_irq, 4'b0111);
      do_write(2'd0, 64'h1100, 1'b0);
      chk("R10 raise beats ack", ipi_irq, 4'b0001);
      chk("R10 duplicate raise warns", warn_pulse, 1);
      do_write(2'd0, 64'h0100, 1'b0);
      chk("R10 plain ack clears", ipi_irq, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raise();
      t_redundant();
      t_tick_and_combo();
      t_empty();
      t_readback();
      t_dedicated();
      t_cpu_limit();
      t_set_wins();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule